// File: doc/BRIEF.md
# Two-Wire Slave Receiver with Host-Decided Acknowledge

This block is the receive side of a slave on a two-wire serial bus of the SMBus/I2C kind. It samples the bus clock and data lines with the system clock and recognises START and STOP. It then shifts in an address byte and any data bytes that follow. The block never acknowledges on its own. At the end of every accepted byte it raises an acknowledge-request flag and an interrupt, and it holds the bus clock low. It keeps holding the clock until the host side has decided what to answer.

The host side works through a small set of signals. It writes the acknowledge decision, clears the interrupt and reads the received byte. It can also inhibit slave operation. If the host refuses an address, the block stays silent for the rest of that transfer and wakes up again at the next START. A host write to the data register while the block is an active receiver is turned into a request to switch to transmitting. The transmit path itself belongs to another block.

Top module: `twsr_slave_rx`

## Requirements
- R1: While `inhibit` is 1 when a START is detected, the following transfer raises no interrupt, does not stretch the clock and leaves SDA released during the ninth clock, even if the address matches.
- R2: An address byte is accepted only if its seven most significant bits equal `own_addr` and its least significant bit is 0, which means write. An accepted address sets `irq` and `ack_req` and sets `rx_mode` to 1. Any other address byte, including a read to the own address, raises nothing and is not acknowledged.
- R3: While `ack_req` or `irq` is set, `scl_drive_low` is 1. The clock is released only after the host has both written the acknowledge bit (a `host_ack_wr` pulse clears `ack_req`) and cleared the interrupt (an `irq_clr` pulse).
- R4: During the ninth clock, `sda_drive_low` is 1 if the last written acknowledge value `host_ack` was 1, which means ACK. It is 0 if that value was 0, which means NACK. SDA is released again at the falling edge of that ninth clock.
- R5: After the host NACKs an address, no interrupt and no clock stretching occur for any further byte until the next START. That next START, even a repeated one, is served normally.
- R6: After each data byte that follows an acknowledged address, `rx_data` holds the byte (first bit received in bit 7), and `ack_req` and `irq` are set before the ninth clock begins. Any number of data bytes, including none, may follow.
- R7: A STOP ends slave-receiver mode. After it, `rx_mode` is 0 and no interrupt is pending.
- R8: A `data_wr` pulse while `rx_mode` is 1 sets `tx_switch_req`. A pulse while `rx_mode` is 0 has no effect. START and STOP clear `tx_switch_req`.
- R9: A repeated START in the middle of a byte discards the partial byte and leaves `rx_data` unchanged. The block then expects a fresh address byte.
- R10: After reset, `irq`, `ack_req`, `rx_mode`, `tx_switch_req`, `scl_drive_low`, `sda_drive_low` and `rx_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_in | input | 1 | Bus clock line as seen on the wire |
| sda_in | input | 1 | Bus data line as seen on the wire |
| scl_drive_low | output | 1 | 1 pulls the bus clock low (stretching) |
| sda_drive_low | output | 1 | 1 pulls the bus data line low (ACK) |
| own_addr | input | BYTE_W-1 | Programmable slave address |
| inhibit | input | 1 | 1 suppresses slave operation at START |
| host_ack | input | 1 | Acknowledge decision, 1 = ACK, 0 = NACK |
| host_ack_wr | input | 1 | Pulse: store `host_ack`, clear `ack_req` |
| irq_clr | input | 1 | Pulse: clear `irq` |
| data_wr | input | 1 | Pulse: host write to the data register |
| rx_data | output | BYTE_W | Last received data byte |
| ack_req | output | 1 | A byte awaits the host's ACK/NACK decision |
| irq | output | 1 | Slave interrupt flag |
| rx_mode | output | 1 | Block is an active slave receiver |
| tx_switch_req | output | 1 | Request to switch to slave transmitting |

## Verification
The assertions check four rules on every cycle: a pending flag always holds the clock low, the interrupt never rises without the acknowledge request, SDA only starts being driven while the clock is held, and a STOP always ends receiver mode. The mode-switch request is also checked to appear only from receiver mode. What the bench's scenarios alone can show is the following: which addresses are accepted, the bit order in `rx_data`, the ACK level seen on the wire, silence after a refused address or under inhibit, and recovery after a repeated START mid-byte. The bench sweeps every 7-bit write address and drives a bus master that honours clock stretching.

// File: rtl/twsr_pkg.sv
package twsr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SHIFT,
      ST_HOLD,
      ST_ACK_SETUP,
      ST_ACK_RISE,
      ST_ACK_FALL,
      ST_BLOCK
   } twsr_state_e;

endpackage

// File: rtl/twsr_line_cond.sv
module twsr_line_cond #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   logic [SYNC_STAGES-1:0] scl_ff;
   logic [SYNC_STAGES-1:0] sda_ff;
   logic                   scl_p;
   logic                   sda_p;
   logic                   scl_s;

   genvar g;
   generate
      for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_ff[0] <= 1'b1;
                  sda_ff[0] <= 1'b1;
               end else begin
                  scl_ff[0] <= scl_in;
                  sda_ff[0] <= sda_in;
               end
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  scl_ff[g] <= 1'b1;
                  sda_ff[g] <= 1'b1;
               end else begin
                  scl_ff[g] <= scl_ff[g-1];
                  sda_ff[g] <= sda_ff[g-1];
               end
            end
         end
      end
   endgenerate

   assign scl_s = scl_ff[SYNC_STAGES-1];
   assign sda_s = sda_ff[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   // data edges qualify as bus conditions only while the clock stays high
   assign scl_rise  = scl_s & ~scl_p;
   assign scl_fall  = ~scl_s & scl_p;
   assign start_det = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/twsr_shifter.sv
module twsr_shifter #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              shift_en,
   input  logic              bit_in,
   output logic [BYTE_W-1:0] byte_q,
   output logic              full
);

   localparam int CNT_W = $clog2(BYTE_W + 1);

   logic [CNT_W-1:0] count;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_q <= '0;
         count  <= '0;
      end else if (clear) begin
         count  <= '0;
      end else if (shift_en) begin
         byte_q <= {byte_q[BYTE_W-2:0], bit_in};
         count  <= count + 1'b1;
      end
   end

   assign full = (count == CNT_W'(BYTE_W));

endmodule

// File: rtl/twsr_host_regs.sv
module twsr_host_regs #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_req,
   input  logic              host_ack,
   input  logic              host_ack_wr,
   input  logic              irq_clr,
   input  logic              data_wr,
   input  logic              rx_mode,
   input  logic              bus_clr,
   input  logic              load_data,
   input  logic [BYTE_W-1:0] data_in,
   output logic              ack_req,
   output logic              irq,
   output logic              ack_bit,
   output logic [BYTE_W-1:0] rx_data,
   output logic              tx_switch_req
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_req       <= 1'b0;
         irq           <= 1'b0;
         ack_bit       <= 1'b0;
         rx_data       <= '0;
         tx_switch_req <= 1'b0;
      end else begin
         if (set_req)          ack_req <= 1'b1;
         else if (host_ack_wr) ack_req <= 1'b0;

         if (set_req)      irq <= 1'b1;
         else if (irq_clr) irq <= 1'b0;

         if (host_ack_wr) ack_bit <= host_ack;
         if (load_data)   rx_data <= data_in;

         if (bus_clr)                 tx_switch_req <= 1'b0;
         else if (data_wr && rx_mode) tx_switch_req <= 1'b1;
      end
   end

endmodule

// File: rtl/twsr_slave_rx.sv
module twsr_slave_rx
   import twsr_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int SYNC_STAGES = 2,
   localparam int ADDR_W     = BYTE_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              scl_drive_low,
   output logic              sda_drive_low,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              inhibit,
   input  logic              host_ack,
   input  logic              host_ack_wr,
   input  logic              irq_clr,
   input  logic              data_wr,
   output logic [BYTE_W-1:0] rx_data,
   output logic              ack_req,
   output logic              irq,
   output logic              rx_mode,
   output logic              tx_switch_req
);

   initial begin
      if (BYTE_W < 2)      $error("twsr_slave_rx: BYTE_W must be at least 2");
      if (SYNC_STAGES < 2) $error("twsr_slave_rx: SYNC_STAGES must be at least 2");
   end

   logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic              shift_en, sh_clear, sh_full;
   logic [BYTE_W-1:0] sh_byte;
   logic              set_req, load_data, ack_bit;
   logic              addr_hit;

   twsr_state_e state, state_n;
   logic        is_addr, is_addr_n;
   logic        rx_mode_n;
   logic        sda_q, sda_n;

   twsr_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_in    (scl_in),
      .sda_in    (sda_in),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   twsr_shifter #(.BYTE_W(BYTE_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (sh_clear),
      .shift_en (shift_en),
      .bit_in   (sda_s),
      .byte_q   (sh_byte),
      .full     (sh_full)
   );

   twsr_host_regs #(.BYTE_W(BYTE_W)) u_regs (
      .clk           (clk),
      .rst_n         (rst_n),
      .set_req       (set_req),
      .host_ack      (host_ack),
      .host_ack_wr   (host_ack_wr),
      .irq_clr       (irq_clr),
      .data_wr       (data_wr),
      .rx_mode       (rx_mode),
      .bus_clr       (start_det | stop_det),
      .load_data     (load_data),
      .data_in       (sh_byte),
      .ack_req       (ack_req),
      .irq           (irq),
      .ack_bit       (ack_bit),
      .rx_data       (rx_data),
      .tx_switch_req (tx_switch_req)
   );

   // address bits in the upper part of the byte, direction bit last (0 = write)
   assign addr_hit = (sh_byte[BYTE_W-1:1] == own_addr) && !sh_byte[0];

   always_comb begin
      state_n   = state;
      is_addr_n = is_addr;
      rx_mode_n = rx_mode;
      sda_n     = sda_q;
      shift_en  = 1'b0;
      sh_clear  = 1'b0;
      set_req   = 1'b0;
      load_data = 1'b0;
      if (start_det) begin
         sda_n     = 1'b0;
         rx_mode_n = 1'b0;
         sh_clear  = 1'b1;
         is_addr_n = 1'b1;
         state_n   = inhibit ? ST_IDLE : ST_SHIFT;
      end else if (stop_det) begin
         sda_n     = 1'b0;
         rx_mode_n = 1'b0;
         state_n   = ST_IDLE;
      end else begin
         unique case (state)
            ST_SHIFT: begin
               if (sh_full) begin
                  if (scl_fall) begin
                     if (!is_addr) begin
                        set_req   = 1'b1;
                        load_data = 1'b1;
                        state_n   = ST_HOLD;
                     end else if (addr_hit) begin
                        set_req   = 1'b1;
                        rx_mode_n = 1'b1;
                        state_n   = ST_HOLD;
                     end else begin
                        state_n   = ST_BLOCK;
                     end
                  end
               end else if (scl_rise) begin
                  shift_en = 1'b1;
               end
            end
            ST_HOLD: begin
               if (!ack_req && !irq) begin
                  sda_n   = ack_bit;
                  state_n = ST_ACK_SETUP;
               end
            end
            ST_ACK_SETUP: state_n = ST_ACK_RISE;
            ST_ACK_RISE: begin
               if (scl_rise) state_n = ST_ACK_FALL;
            end
            ST_ACK_FALL: begin
               if (scl_fall) begin
                  sda_n     = 1'b0;
                  sh_clear  = 1'b1;
                  is_addr_n = 1'b0;
                  if (is_addr && !ack_bit) begin
                     rx_mode_n = 1'b0;
                     state_n   = ST_BLOCK;
                  end else begin
                     state_n   = ST_SHIFT;
                  end
               end
            end
            ST_IDLE, ST_BLOCK: ;
            default: state_n = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         is_addr <= 1'b0;
         rx_mode <= 1'b0;
         sda_q   <= 1'b0;
      end else begin
         state   <= state_n;
         is_addr <= is_addr_n;
         rx_mode <= rx_mode_n;
         sda_q   <= sda_n;
      end
   end

   assign scl_drive_low = (state == ST_HOLD) || (state == ST_ACK_SETUP);
   assign sda_drive_low = sda_q;

endmodule

// File: rtl/twsr_slave_rx_chk.sv
module twsr_slave_rx_chk (
   input logic clk,
   input logic rst_n,
   input logic ack_req,
   input logic irq,
   input logic scl_drive_low,
   input logic sda_drive_low,
   input logic rx_mode,
   input logic tx_switch_req,
   input logic stop_det
);

   p_hold_scl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_req || irq) |-> scl_drive_low);

   p_irq_with_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ack_req);

   p_sda_under_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_drive_low) |-> scl_drive_low);

   p_stop_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !rx_mode);

   p_tx_from_rx_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_switch_req) |-> $past(rx_mode));

endmodule

bind twsr_slave_rx twsr_slave_rx_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .ack_req       (ack_req),
   .irq           (irq),
   .scl_drive_low (scl_drive_low),
   .sda_drive_low (sda_drive_low),
   .rx_mode       (rx_mode),
   .tx_switch_req (tx_switch_req),
   .stop_det      (stop_det)
);

// File: tb/twsr_slave_rx_test.sv
module twsr_slave_rx_test;

   localparam int H = 8;
   localparam logic [6:0] OWN = 7'h3A;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1, m_sda = 1'b1;
   logic scl_drive_low, sda_drive_low;
   logic inhibit = 1'b0, host_ack = 1'b0, host_ack_wr = 1'b0, irq_clr = 1'b0, data_wr = 1'b0;
   logic [7:0] rx_data;
   logic ack_req, irq, rx_mode, tx_switch_req;
   logic scl_line, sda_line;
   int n_tests = 0, n_fail = 0;

   always #5 clk = ~clk;

   assign scl_line = m_scl & ~scl_drive_low;
   assign sda_line = m_sda & ~sda_drive_low;

   twsr_slave_rx uut (
      .clk (clk), .rst_n (rst_n), .scl_in (scl_line), .sda_in (sda_line),
      .scl_drive_low (scl_drive_low), .sda_drive_low (sda_drive_low),
      .own_addr (OWN), .inhibit (inhibit), .host_ack (host_ack),
      .host_ack_wr (host_ack_wr), .irq_clr (irq_clr), .data_wr (data_wr),
      .rx_data (rx_data), .ack_req (ack_req), .irq (irq), .rx_mode (rx_mode),
      .tx_switch_req (tx_switch_req)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_start();
      m_sda = 1'b1; tick(H);
      m_scl = 1'b1; tick(H);
      m_sda = 1'b0; tick(H);
      m_scl = 1'b0; tick(H);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; tick(H);
      m_scl = 1'b1; tick(H);
      m_sda = 1'b1; tick(2 * H);
   endtask

   task automatic bus_bit(input logic b);
      m_sda = b; tick(H);
      m_scl = 1'b1;
      while (!scl_line) tick(1);
      tick(H);
      m_scl = 1'b0; tick(H);
   endtask

   task automatic bus_byte(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) bus_bit(b[i]);
   endtask

   // ninth clock; returns the SDA level seen while SCL is high
   task automatic ack_clock(output logic seen);
      m_sda = 1'b1; tick(H);
      m_scl = 1'b1;
      while (!scl_line) tick(1);
      tick(H / 2);
      seen = sda_line;
      tick(H / 2);
      m_scl = 1'b0; tick(H);
   endtask

   task automatic host_answer(input logic ack);
      host_ack = ack; host_ack_wr = 1'b1; tick(1);
      host_ack_wr = 1'b0; tick(1);
      chk("R3 ack written, irq pending: clock still held", int'(scl_drive_low), 1);
      irq_clr = 1'b1; tick(1);
      irq_clr = 1'b0; tick(3);
      chk("R3 clock released after ack and clear", int'(scl_drive_low), 0);
      chk("R4 sda drive level before ninth clock", int'(sda_drive_low), int'(ack));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog (R1..R10 run) actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic seen;
      logic [7:0] pats [6];
      pats = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};
      tick(3);
      rst_n = 1'b1;
      tick(2);
      // R10 reset state
      chk("R10 irq", int'(irq), 0);
      chk("R10 ack_req", int'(ack_req), 0);
      chk("R10 rx_mode", int'(rx_mode), 0);
      chk("R10 tx_switch_req", int'(tx_switch_req), 0);
      chk("R10 scl_drive_low", int'(scl_drive_low), 0);
      chk("R10 sda_drive_low", int'(sda_drive_low), 0);
      chk("R10 rx_data", int'(rx_data), 0);

      // R2 sweep over every 7-bit write address; R7 with zero data bytes
      for (int a = 0; a < 128; a++) begin
         bus_start();
         bus_byte({a[6:0], 1'b0});
         chk("R2 irq on address match", int'(irq), int'(a == int'(OWN)));
         chk("R2 stretch on address match", int'(scl_drive_low), int'(a == int'(OWN)));
         if (irq) host_answer(1'b1);
         ack_clock(seen);
         chk("R2 address acknowledged on wire", int'(seen), int'(a != int'(OWN)));
         bus_stop();
         chk("R7 rx_mode after stop", int'(rx_mode), 0);
         chk("R7 no pending irq after stop", int'(irq), 0);
      end

      // R2 read to own address is ignored
      bus_start();
      bus_byte({OWN, 1'b1});
      chk("R2 read direction raises nothing", int'(irq), 0);
      ack_clock(seen);
      chk("R2 read direction not acked", int'(seen), 1);
      bus_stop();

      // R8 write while idle has no effect
      data_wr = 1'b1; tick(1); data_wr = 1'b0; tick(2);
      chk("R8 data_wr outside rx mode ignored", int'(tx_switch_req), 0);

      // R6 data bytes, last one NACKed
      bus_start();
      bus_byte({OWN, 1'b0});
      chk("R2 rx_mode after accepted address", int'(rx_mode), 1);
      host_answer(1'b1);
      ack_clock(seen);
      for (int i = 0; i < 6; i++) begin
         bus_byte(pats[i]);
         chk("R6 irq after data byte", int'(irq), 1);
         chk("R6 ack_req after data byte", int'(ack_req), 1);
         chk("R6 rx_data byte value", int'(rx_data), int'(pats[i]));
         host_answer(i != 5);
         ack_clock(seen);
         chk("R4 data ACK level on wire", int'(seen), int'(i == 5));
         tick(4);
         chk("R4 sda released after ninth clock", int'(sda_drive_low), 0);
      end
      data_wr = 1'b1; tick(1); data_wr = 1'b0; tick(2);
      chk("R8 data_wr in rx mode sets request", int'(tx_switch_req), 1);
      bus_stop();
      chk("R8 stop clears request", int'(tx_switch_req), 0);
      chk("R7 rx_mode cleared by stop", int'(rx_mode), 0);

      // R5 NACKed address silences the transfer until next START
      bus_start();
      bus_byte({OWN, 1'b0});
      host_answer(1'b0);
      ack_clock(seen);
      chk("R4 address NACK on wire", int'(seen), 1);
      chk("R5 rx_mode left after address NACK", int'(rx_mode), 0);
      bus_byte(8'h55);
      chk("R5 no irq after refused address", int'(irq), 0);
      chk("R5 no stretch after refused address", int'(scl_drive_low), 0);
      ack_clock(seen);
      chk("R5 no ack after refused address", int'(seen), 1);
      chk("R5 rx_data untouched", int'(rx_data), 8'h80);
      bus_start();
      bus_byte({OWN, 1'b0});
      chk("R5 next START served again", int'(irq), 1);
      host_answer(1'b1);
      ack_clock(seen);
      bus_stop();

      // R1 inhibit at START
      inhibit = 1'b1;
      bus_start();
      bus_byte({OWN, 1'b0});
      chk("R1 inhibited: no irq", int'(irq), 0);
      chk("R1 inhibited: no stretch", int'(scl_drive_low), 0);
      ack_clock(seen);
      chk("R1 inhibited: no ack", int'(seen), 1);
      bus_stop();
      inhibit = 1'b0;

      // R9 repeated START in the middle of a data byte
      bus_start();
      bus_byte({OWN, 1'b0});
      host_answer(1'b1);
      ack_clock(seen);
      for (int i = 7; i >= 4; i--) bus_bit(i[0]);
      bus_start();
      chk("R9 partial byte discarded", int'(rx_data), 8'h80);
      chk("R9 no irq from partial byte", int'(irq), 0);
      bus_byte({OWN, 1'b0});
      chk("R9 address expected after repeated START", int'(irq), 1);
      host_answer(1'b1);
      ack_clock(seen);
      bus_byte(8'h3C);
      chk("R9 next full byte received", int'(rx_data), 8'h3C);
      host_answer(1'b1);
      ack_clock(seen);
      chk("R4 ack after repeated START", int'(seen), 0);
      bus_stop();

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule